// File: doc/BRIEF.md
# Two-Level Task Dispatcher with Neighbour Worker Borrowing

This block hands out work items to a pool of 32 scalar workers grouped as four clusters of eight. A host offers one request at a time (a 6-bit task number plus the cluster it is aimed at) over a valid/ready handshake. A top-level manager buffers the requests and forwards each to the local manager of its target cluster. Every local manager buffers its own requests and starts each one on a free worker, raising a one-cycle start strobe and the task number on that worker's lane. A worker stays marked as occupied until it answers with a one-cycle done pulse.

Each manager, top-level or local, owns a 16-deep queue and serves its head no more often than once every 20 cycles, which keeps task hand-off fine-grained and predictable. Inside a cluster the free worker is picked round-robin. When every worker of a cluster is occupied, its manager may start the task on a free worker of the next cluster around a ring of four, so that a saturated cluster borrows spare capacity instead of waiting. Queue fill levels are visible at the ports.

Top module: `tdu_top`

## Requirements
- R1: After reset req_ready is 1, gq_level and every lq_level field are 0, and no wk_start bit is raised.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1; req_ready is 0 exactly while the top-level queue holds 16 entries, and a held request is never lost.
- R3: Each of the five queues holds up to 16 entries and serves in arrival order; the top-level head waits while the queue of its target cluster is full, and the tasks of one cluster are started in the order they were accepted.
- R4: Two successive services of the same queue (forwarding for the top-level queue, worker start for a local queue) are at least 20 cycles apart.
- R5: Starting a task raises wk_start[c*8+k] for one cycle with the task number on wk_task[(c*8+k)*6 +: 6] in the same cycle; an occupied worker is never started.
- R6: A local manager starts its head on a free worker of its own cluster when one exists, choosing the first free worker at or after a round-robin pointer (reset 0, wrapping at 8) that then moves to one past the chosen worker.
- R7: When all eight workers of cluster c are occupied, its manager may start its head only on a free worker of cluster (c+1) mod 4, chosen with that cluster's pointer, never one its owner takes in the same cycle; the lending cluster's pointer then moves to one past the lent worker.
- R8: A done pulse on wk_done[w] frees worker w, which can be started again from the following cycle on.
- R9: gq_level gives the top-level queue's entry count and lq_level[c*5 +: 5] that of cluster c's queue.
- R10: When neither the own cluster nor the next cluster has a free worker, the head task of a local queue waits and nothing is started for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Top-level queue can take a request |
| req_cluster | input | 2 | Target cluster of the request |
| req_task | input | 6 | Task number of the request |
| wk_done | input | 32 | One-cycle completion pulse per worker |
| wk_start | output | 32 | One-cycle start strobe per worker |
| wk_task | output | 192 | Task number lane per worker, 6 bits each |
| gq_level | output | 5 | Entry count of the top-level queue |
| lq_level | output | 20 | Entry count of each local queue, 5 bits each |

## Verification
A corrupted occupancy bit shows at the ports either as a start on a worker that never sent done, caught on the very strobe, or as a task held back while a worker is idle, seen as a missing start within one service gap. A drifting round-robin pointer shows as the wrong lane on the next start of that cluster, and a lost or duplicated queue entry shows as a task number out of order on the first start past it. A pacing counter that runs short shows as two starts from one cluster closer than 20 cycles apart.

// File: rtl/tdu_pkg.sv
package tdu_pkg;
    localparam int unsigned NCL    = 4;
    localparam int unsigned NWK    = 8;
    localparam int unsigned IDW    = 6;
    localparam int unsigned QDEPTH = 16;
    localparam int unsigned GAP    = 20;
    localparam int unsigned CLW    = $clog2(NCL);
    localparam int unsigned WKW    = $clog2(NWK);
    localparam int unsigned NWT    = NCL * NWK;

    typedef logic [IDW-1:0] task_id_t;
    typedef logic [NWK-1:0] wk_mask_t;
    typedef logic [WKW-1:0] wk_idx_t;

    typedef struct packed {
        logic [CLW-1:0] dest;
        task_id_t       tid;
    } req_t;

    typedef struct packed {
        logic    hit;
        wk_idx_t idx;
    } pick_t;

    // first set bit of free at or after ptr, wrapping
    function automatic pick_t rr_pick(input wk_mask_t free, input wk_idx_t ptr);
        pick_t r;
        r = '0;
        for (int k = NWK - 1; k >= 0; k--) begin
            wk_idx_t j;
            j = ptr + wk_idx_t'(k);
            if (free[j]) begin
                r.hit = 1'b1;
                r.idx = j;
            end
        end
        return r;
    endfunction

    function automatic wk_idx_t oh_index(input wk_mask_t oh);
        wk_idx_t r;
        r = '0;
        for (int k = 0; k < NWK; k++)
            if (oh[k]) r = wk_idx_t'(k);
        return r;
    endfunction
endpackage

// File: rtl/tdu_fifo.sv
module tdu_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LVW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  logic [W-1:0]   din,
    input  logic           pop,
    output logic [W-1:0]   dout,
    output logic           full,
    output logic           empty,
    output logic [LVW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LVW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            cnt <= cnt + LVW'(push) - LVW'(pop);
        end
    end

    always_ff @(posedge clk)
        if (push) mem[wp] <= din;

    assign dout  = mem[rp];
    assign full  = (cnt == LVW'(DEPTH));
    assign empty = (cnt == '0);
    assign level = cnt;

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
    p_level_bound_r9: assert property (@(posedge clk) disable iff (rst) level <= LVW'(DEPTH));
endmodule

// File: rtl/tdu_pacer.sv
module tdu_pacer #(
    parameter int unsigned GAP = 20,
    localparam int unsigned CW = $clog2(GAP + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic ok
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (fire)      cnt <= CW'(GAP - 1);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign ok = (cnt == '0);

    // independent watch on spacing between services
    logic [CW-1:0] since;
    logic          seen;
    always_ff @(posedge clk) begin
        if (rst) begin
            since <= '0;
            seen  <= 1'b0;
        end else if (fire) begin
            since <= '0;
            seen  <= 1'b1;
        end else if (since != CW'(GAP)) begin
            since <= since + 1'b1;
        end
    end

    p_service_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && seen) |-> (since >= CW'(GAP - 1)));
endmodule

// File: rtl/tdu_pool.sv
module tdu_pool
    import tdu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wk_mask_t           done,
    input  wk_mask_t           own_gnt,
    input  task_id_t           own_tid,
    input  wk_mask_t           lend_gnt,
    input  task_id_t           lend_tid,
    output wk_mask_t           busy,
    output wk_idx_t            ptr,
    output wk_mask_t           start,
    output logic [NWK*IDW-1:0] tid_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= '0;
            ptr     <= '0;
            start   <= '0;
            tid_out <= '0;
        end else begin
            busy  <= (busy & ~done) | own_gnt | lend_gnt;
            start <= own_gnt | lend_gnt;
            for (int k = 0; k < NWK; k++) begin
                if (own_gnt[k])       tid_out[k*IDW +: IDW] <= own_tid;
                else if (lend_gnt[k]) tid_out[k*IDW +: IDW] <= lend_tid;
            end
            if (|lend_gnt)     ptr <= oh_index(lend_gnt) + 1'b1;
            else if (|own_gnt) ptr <= oh_index(own_gnt) + 1'b1;
        end
    end

    p_free_only_r5: assert property (@(posedge clk) disable iff (rst)
        ((own_gnt | lend_gnt) & busy) == '0);
    p_single_owner_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(own_gnt) && $onehot0(lend_gnt) && ((own_gnt & lend_gnt) == '0));
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (|done) |=> ((busy & $past(done & ~(own_gnt | lend_gnt))) == '0));
endmodule

// File: rtl/tdu_local.sv
module tdu_local
    import tdu_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned GAP   = 20,
    localparam int unsigned LVW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  task_id_t       push_tid,
    output logic           full,
    output logic [LVW-1:0] level,
    input  wk_mask_t       own_busy,
    input  wk_idx_t        own_ptr,
    input  wk_mask_t       nbr_busy,
    input  wk_idx_t        nbr_ptr,
    input  wk_mask_t       nbr_own_gnt,
    output wk_mask_t       own_gnt,
    output wk_mask_t       brw_gnt,
    output task_id_t       head_tid
);
    logic  empty, ok, want, pop;
    pick_t own_p, nbr_p;

    tdu_fifo #(.W(IDW), .DEPTH(DEPTH)) u_q (
        .clk(clk), .rst(rst), .push(push), .din(push_tid), .pop(pop),
        .dout(head_tid), .full(full), .empty(empty), .level(level)
    );

    tdu_pacer #(.GAP(GAP)) u_pace (.clk(clk), .rst(rst), .fire(pop), .ok(ok));

    always_comb begin
        want    = !empty && ok;
        own_p   = rr_pick(~own_busy, own_ptr);
        nbr_p   = rr_pick(~nbr_busy & ~nbr_own_gnt, nbr_ptr);
        own_gnt = '0;
        brw_gnt = '0;
        if (want && own_p.hit)
            own_gnt = wk_mask_t'(1) << own_p.idx;
        else if (want && nbr_p.hit)
            brw_gnt = wk_mask_t'(1) << nbr_p.idx;
        pop = (|own_gnt) || (|brw_gnt);
    end

    p_local_first_r6: assert property (@(posedge clk) disable iff (rst)
        (|brw_gnt) |-> (&own_busy));
    p_borrow_free_r7: assert property (@(posedge clk) disable iff (rst)
        (brw_gnt & (nbr_busy | nbr_own_gnt)) == '0);
endmodule

// File: rtl/tdu_global.sv
module tdu_global
    import tdu_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned GAP   = 20,
    localparam int unsigned LVW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  req_t           in_req,
    output logic           in_ready,
    output logic [LVW-1:0] level,
    input  logic [NCL-1:0] loc_full,
    output logic [NCL-1:0] fwd_push,
    output task_id_t       fwd_tid
);
    logic full, empty, ok, pop, take;
    req_t head;

    assign take = in_valid && in_ready;

    tdu_fifo #(.W($bits(req_t)), .DEPTH(DEPTH)) u_q (
        .clk(clk), .rst(rst), .push(take), .din(in_req), .pop(pop),
        .dout(head), .full(full), .empty(empty), .level(level)
    );

    tdu_pacer #(.GAP(GAP)) u_pace (.clk(clk), .rst(rst), .fire(pop), .ok(ok));

    always_comb begin
        pop      = !empty && ok && !loc_full[head.dest];
        fwd_push = '0;
        if (pop) fwd_push[head.dest] = 1'b1;
    end

    assign in_ready = !full;
    assign fwd_tid  = head.tid;

    p_fwd_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fwd_push) && ((fwd_push & loc_full) == '0));
endmodule

// File: rtl/tdu_top.sv
module tdu_top
    import tdu_pkg::*;
#(
    parameter int unsigned QD   = QDEPTH,
    parameter int unsigned PACE = GAP,
    localparam int unsigned LVW = $clog2(QD + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [CLW-1:0]       req_cluster,
    input  logic [IDW-1:0]       req_task,
    input  logic [NWT-1:0]       wk_done,
    output logic [NWT-1:0]       wk_start,
    output logic [NWT*IDW-1:0]   wk_task,
    output logic [LVW-1:0]       gq_level,
    output logic [NCL*LVW-1:0]   lq_level
);
    logic [NCL-1:0] loc_full, fwd_push;
    task_id_t       fwd_tid;
    req_t           in_req;
    wk_mask_t       busy     [NCL];
    wk_idx_t        ptr      [NCL];
    wk_mask_t       own_gnt  [NCL];
    wk_mask_t       brw_gnt  [NCL];
    task_id_t       head_tid [NCL];

    assign in_req = '{dest: req_cluster, tid: req_task};

    tdu_global #(.DEPTH(QD), .GAP(PACE)) u_glb (
        .clk(clk), .rst(rst), .in_valid(req_valid), .in_req(in_req),
        .in_ready(req_ready), .level(gq_level), .loc_full(loc_full),
        .fwd_push(fwd_push), .fwd_tid(fwd_tid)
    );

    for (genvar c = 0; c < NCL; c++) begin : g_cl
        localparam int NXT = (c + 1) % NCL;
        localparam int PRV = (c + NCL - 1) % NCL;

        tdu_local #(.DEPTH(QD), .GAP(PACE)) u_loc (
            .clk(clk), .rst(rst),
            .push(fwd_push[c]), .push_tid(fwd_tid),
            .full(loc_full[c]), .level(lq_level[c*LVW +: LVW]),
            .own_busy(busy[c]), .own_ptr(ptr[c]),
            .nbr_busy(busy[NXT]), .nbr_ptr(ptr[NXT]), .nbr_own_gnt(own_gnt[NXT]),
            .own_gnt(own_gnt[c]), .brw_gnt(brw_gnt[c]), .head_tid(head_tid[c])
        );

        tdu_pool u_pool (
            .clk(clk), .rst(rst),
            .done(wk_done[c*NWK +: NWK]),
            .own_gnt(own_gnt[c]), .own_tid(head_tid[c]),
            .lend_gnt(brw_gnt[PRV]), .lend_tid(head_tid[PRV]),
            .busy(busy[c]), .ptr(ptr[c]),
            .start(wk_start[c*NWK +: NWK]),
            .tid_out(wk_task[c*NWK*IDW +: NWK*IDW])
        );
    end

    p_reset_quiet_r1: assert property (@(posedge clk) $past(rst) |-> (wk_start == '0));
endmodule

// File: tb/sim_tdu_top.sv
module sim_tdu_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_cluster = '0;
    logic [5:0]   req_task = '0;
    logic [31:0]  wk_done = '0;
    logic [31:0]  wk_start;
    logic [191:0] wk_task;
    logic [4:0]   gq_level;
    logic [19:0]  lq_level;

    always #2 clk = ~clk;   // 250 MHz

    tdu_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_cluster(req_cluster), .req_task(req_task), .wk_done(wk_done),
        .wk_start(wk_start), .wk_task(wk_task), .gq_level(gq_level), .lq_level(lq_level)
    );

    int nchk = 0, nfail = 0, cyc = 0, accepted = 0;
    int got_w [64];
    int last_cyc [4];
    int acnt [32];
    bit auto_on = 1'b0;
    logic [31:0] busy_m = '0, done_req = '0, prev_start = '0;
    logic [5:0] q0[$], q1[$], q2[$], q3[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int qsize(input int t);
        case (t)
            0: return q0.size();
            1: return q1.size();
            2: return q2.size();
            default: return q3.size();
        endcase
    endfunction

    function automatic int qpop(input int t);
        case (t)
            0: return int'(q0.pop_front());
            1: return int'(q1.pop_front());
            2: return int'(q2.pop_front());
            default: return int'(q3.pop_front());
        endcase
    endfunction

    task automatic qpush(input int t, input int id);
        case (t)
            0: q0.push_back(6'(id));
            1: q1.push_back(6'(id));
            2: q2.push_back(6'(id));
            default: q3.push_back(6'(id));
        endcase
    endtask

    // monitor, worker model and watchdog
    always @(negedge clk) begin
        logic [31:0] dn;
        cyc++;
        if (cyc > 100000) begin
            chk(1'b0, "watchdog", cyc, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
        dn = done_req;
        done_req = '0;
        for (int w = 0; w < 32; w++) begin
            if (acnt[w] > 0) begin
                acnt[w]--;
                if (acnt[w] == 0) dn[w] = 1'b1;
            end
        end
        wk_done = dn;
        busy_m = busy_m & ~dn;
        if (!rst) begin
            for (int w = 0; w < 32; w++) begin
                if (wk_start[w]) begin
                    int id, tag, own, e;
                    id  = int'(wk_task[w*6 +: 6]);
                    tag = id / 16;
                    own = w / 8;
                    chk(!prev_start[w], "R5 strobe one cycle", 1, 0);
                    chk(!busy_m[w], "R5 start on idle worker", w, -1);
                    chk(own == tag || own == (tag + 1) % 4, "R7 borrow only from next cluster", own, tag);
                    e = (qsize(tag) > 0) ? qpop(tag) : -1;
                    chk(e == id, "R3 arrival order", id, e);
                    chk(cyc - last_cyc[tag] >= 20, "R4 service gap", cyc - last_cyc[tag], 20);
                    last_cyc[tag] = cyc;
                    got_w[id] = w;
                    busy_m[w] = 1'b1;
                    if (auto_on) acnt[w] = 4;
                end
            end
        end
        prev_start = wk_start;
    end

    task automatic send(input int cl, input int id);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid   = 1'b1;
        req_cluster = 2'(cl);
        req_task    = 6'(id);
        qpush(id / 16, id);
        @(posedge clk);
        #1 req_valid = 1'b0;
        accepted++;
    endtask

    task automatic pulse_done(input int w);
        @(posedge clk);
        done_req[w] = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic wait_id(input int id);
        for (int k = 0; k < 600 && got_w[id] < 0; k++) @(posedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) got_w[i] = -1;
        for (int i = 0; i < 4; i++) last_cyc[i] = -1000;
        for (int i = 0; i < 32; i++) acnt[i] = 0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(gq_level == 0 && lq_level == 0, "R1 levels after reset", int'(gq_level), 0);
        chk(wk_start == 0, "R1 no start after reset", int'(wk_start), 0);

        // R6: eight tasks fill cluster 0 in round-robin order
        for (int i = 0; i < 8; i++) send(0, i);
        wait_id(7);
        for (int i = 0; i < 8; i++) chk(got_w[i] == i, "R6 round-robin pick", got_w[i], i);

        // R7: saturated cluster 0 borrows worker 8 of cluster 1
        send(0, 8);
        wait_id(8);
        chk(got_w[8] == 8, "R7 borrow from cluster 1", got_w[8], 8);

        // R7 lender pointer moved past lent worker
        send(1, 16);
        wait_id(16);
        chk(got_w[16] == 9, "R7 lender pointer advance", got_w[16], 9);

        // R8 + R6: freed local worker preferred over free neighbour workers
        pulse_done(3);
        send(0, 9);
        wait_id(9);
        chk(got_w[9] == 3, "R8 freed worker reused locally", got_w[9], 3);

        // fill cluster 1
        for (int i = 17; i < 23; i++) send(1, i);
        wait_id(22);
        chk(got_w[22] == 15, "R6 cluster 1 fill", got_w[22], 15);

        // R10: no free worker in own or next cluster
        send(0, 10);
        repeat (100) @(posedge clk);
        chk(got_w[10] == -1, "R10 head waits", got_w[10], -1);
        pulse_done(12);
        wait_id(10);
        chk(got_w[10] == 12, "R8 borrowed freed worker", got_w[10], 12);

        // R7 ring wrap: cluster 3 borrows from cluster 0
        pulse_done(5);
        for (int i = 48; i < 57; i++) send(3, i);
        wait_id(56);
        chk(got_w[55] == 31, "R6 cluster 3 fill", got_w[55], 31);
        chk(got_w[56] == 5, "R7 ring wrap to cluster 0", got_w[56], 5);

        // R2 / R3 / R9: back-pressure with clusters 0 and 1 saturated
        accepted = 0;
        fork
            for (int i = 0; i < 33; i++) send(0, i % 16);
        join_none
        repeat (700) @(posedge clk);
        @(negedge clk);
        chk(accepted == 32, "R2 accepted before stall", accepted, 32);
        chk(req_ready == 1'b0, "R2 ready low when full", int'(req_ready), 0);
        chk(gq_level == 16, "R9 top-level count", int'(gq_level), 16);
        chk(lq_level[4:0] == 16, "R3 local queue capacity", int'(lq_level[4:0]), 16);

        // release every worker, let them finish automatically
        @(posedge clk);
        auto_on = 1'b1;
        done_req = busy_m;
        for (int k = 0; k < 2000 && (qsize(0) + qsize(1) + qsize(2) + qsize(3)) > 0; k++)
            @(posedge clk);
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk(accepted == 33, "R2 no request lost", accepted, 33);
        chk(qsize(0) == 0, "R3 all cluster 0 tasks started", qsize(0), 0);
        chk(req_ready == 1'b1 && gq_level == 0 && lq_level == 0, "R9 queues drained",
            int'(gq_level), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule